// File: doc/BRIEF.md
# Lockable L1 Tag Controller

This block holds the tag, valid and replacement state of an 8-way set-associative level-one cache, and decides what each core lookup becomes. A lookup either hits (the data array may return the line), allocates a way and asks the bus for a burst line fill, or passes straight through as a single-beat cache-inhibited bus access. The data array, dirty-line write-back, address translation and the bus protocol are outside the block. The page inhibit attribute arrives as a plain input, and the bus request leaves as a plain pulse with a beat-type flag.

A three-bit control register gates the behaviour. The enable bit turns tag lookups on. The lock bit freezes the whole array: hits still return data, but misses no longer allocate. The flash-invalidate bit starts a walk that clears every valid bit and every replacement tree, one set per clock. While the walk runs, core access stalls and bus snoops report a miss. Snoops from the bus check and may invalidate lines. A line that a snoop invalidates while the cache is locked stays invalid until the lock is removed.

Top module: `l1_tag_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` is 0 (enable off), `busy` is 0, `req_ready` is 1, and `rsp_valid`, `bus_req` and `snp_hit` are 0.
- R2: A lookup is accepted when `req_valid` and `req_ready` are both 1. Its result appears one cycle later with `rsp_valid`=1. The control register bits are: bit 0 enable, bit 1 lock, bit 2 flash invalidate. When enabled and unlocked, a non-inhibited miss allocates a way and raises `bus_req` with `bus_single`=0 (burst). A later lookup of the same set and tag then gives `rsp_hit`=1, reports the way in `rsp_way`, and leaves `bus_req` at 0.
- R3: The way chosen for a fill is the lowest-numbered invalid way of the set. If all ways are valid, the choice comes from a 7-bit binary tree per set, stored heap-style. Node 0 is the root and the children of node n are 2n+1 and 2n+2. A node value of 0 steers toward the lower-numbered half. Every hit and every fill points each node on the accessed way's path away from that way.
- R4: With enable at 0, no lookup hits. Every access raises `bus_req` with `bus_single`=1 and allocates nothing. Snoops report no hit and invalidate nothing.
- R5: `bus_ci` always equals the `req_inhibit` of the accepted access, in every mode. When enabled, an inhibited access never hits, does not allocate, and is sent single-beat.
- R6: With lock at 1, a hit returns `rsp_hit`=1 as usual. A miss is sent single-beat, allocates nothing and leaves the replacement tree unchanged.
- R7: When enabled and not busy, a snoop sets `snp_hit` one cycle later if its tag is valid in its set. With `snp_inval` at 1, it also invalidates the line, whether or not the lock is set. Under lock the line stays a miss, and it can be refilled only after unlock.
- R8: Writing enable=1 with flash invalidate=1 while idle has these effects. The flash bit reads 1 for exactly one cycle after the write and then 0. `busy` stays high for exactly SETS cycles, and `req_ready` is 0 for that time. Snoops during the walk report no hit. Afterwards every line is invalid and fills start again at way 0.
- R9: A write with the flash-invalidate bit set that arrives while `busy` is high is ignored. The bit reads 0, and the running walk keeps its length.
- R10: A flash-invalidate write with enable=0 pulses the flash bit but does not set `busy` and does not clear any line.
- R11: A control write in the same cycle as an accepted lookup does not affect that lookup. The lookup uses the old enable and lock values, and the new values apply from the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control write data: bit0 enable, bit1 lock, bit2 flash invalidate |
| cfg_rdata | output | 3 | Current control register value |
| busy | output | 1 | Flash-invalidate walk in progress |
| req_valid | input | 1 | Core lookup request |
| req_set | input | log2(SETS) | Lookup set index |
| req_tag | input | TAG_W | Lookup tag |
| req_inhibit | input | 1 | Page cache-inhibit attribute |
| req_ready | output | 1 | Lookup can be accepted |
| rsp_valid | output | 1 | Result of the lookup accepted last cycle |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | log2(WAYS) | Hit way, or allocated way on a fill |
| bus_req | output | 1 | Bus access request |
| bus_single | output | 1 | 1 = single beat, 0 = burst line fill |
| bus_ci | output | 1 | Cache-inhibit signal for the bus access |
| bus_set | output | log2(SETS) | Set of the bus access |
| bus_tag | output | TAG_W | Tag of the bus access |
| snp_valid | input | 1 | Snoop request |
| snp_set | input | log2(SETS) | Snoop set index |
| snp_tag | input | TAG_W | Snoop tag |
| snp_inval | input | 1 | Snoop invalidates on hit |
| snp_hit | output | 1 | Snoop of last cycle hit |

## Verification
The main sequence fills one set past its eight ways while mixing hits between the fills. Each way the bench predicts separates the lowest-invalid rule from the tree walk, and shows whether hits refresh the tree. Inhibited lookups are then placed on a line that is resident, so a missing inhibit bypass shows up as a false hit. Lock, disable and snoop patterns reuse known resident and evicted tags. This tells apart "no allocation" from "allocated but not reported", and "snoop ignored" from "snoop invalidated". The flash walk is probed in its first cycles on a set that is not yet cleared, so a forced snoop miss can be told apart from a line that has already been cleared.

// File: rtl/l1tc_pkg.sv
`timescale 1ns/1ps
package l1tc_pkg;
  localparam int CFG_W    = 3;
  localparam int CFG_EN   = 0;
  localparam int CFG_LOCK = 1;
  localparam int CFG_FINV = 2;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_HIT    = 2'd1,
    ACC_FILL   = 2'd2,
    ACC_SINGLE = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/l1tc_cfg_seq.sv
`timescale 1ns/1ps
// Control register and flash-invalidate set walker.
module l1tc_cfg_seq
  import l1tc_pkg::*;
#(
  parameter  int SETS  = 16,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic             busy,
  output logic [SET_W-1:0] clr_set
);
  logic             en_q, en_d;
  logic             lock_q, lock_d;
  logic             finv_q, finv_d;
  logic             busy_q, busy_d;
  logic [SET_W-1:0] cnt_q, cnt_d;
  logic             start, go_inv, last;

  always_comb begin
    start  = cfg_we & cfg_wdata[CFG_FINV] & ~busy_q;
    go_inv = start & cfg_wdata[CFG_EN];
    last   = busy_q & (cnt_q == SET_W'(SETS - 1));
    en_d   = cfg_we ? cfg_wdata[CFG_EN]   : en_q;
    lock_d = cfg_we ? cfg_wdata[CFG_LOCK] : lock_q;
    finv_d = start;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (go_inv) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      lock_q <= 1'b0;
      finv_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      en_q   <= en_d;
      lock_q <= lock_d;
      finv_q <= finv_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    cfg_q           = '0;
    cfg_q[CFG_EN]   = en_q;
    cfg_q[CFG_LOCK] = lock_q;
    cfg_q[CFG_FINV] = finv_q;
    busy            = busy_q;
    clr_set         = cnt_q;
  end
endmodule

// File: rtl/l1tc_tag_store.sv
`timescale 1ns/1ps
// Tag and valid storage with a core port, a snoop port and a set clear.
module l1tc_tag_store #(
  parameter  int SETS  = 16,
  parameter  int WAYS  = 8,
  parameter  int TAG_W = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] core_set,
  input  logic [TAG_W-1:0] core_tag,
  output logic [WAYS-1:0]  core_hit_vec,
  output logic [WAYS-1:0]  core_valid_vec,
  input  logic [SET_W-1:0] snp_set,
  input  logic [TAG_W-1:0] snp_tag,
  output logic [WAYS-1:0]  snp_hit_vec,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             sinv_en,
  input  logic [SET_W-1:0] sinv_set,
  input  logic [WAYS-1:0]  sinv_vec,
  input  logic             clr_en,
  input  logic [SET_W-1:0] clr_set
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  valid_d [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        valid_d[s][w] = valid_q[s][w];
        if (fill_en && fill_set == SET_W'(s) && fill_way == WAY_W'(w))
          valid_d[s][w] = 1'b1;
        if (sinv_en && sinv_set == SET_W'(s) && sinv_vec[w])
          valid_d[s][w] = 1'b0;
        if (clr_en && clr_set == SET_W'(s))
          valid_d[s][w] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= valid_d[s];
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_set][fill_way] <= fill_tag;
  end

  assign core_valid_vec = valid_q[core_set];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign core_hit_vec[w] = valid_q[core_set][w] & (tag_q[core_set][w] == core_tag);
    assign snp_hit_vec[w]  = valid_q[snp_set][w]  & (tag_q[snp_set][w]  == snp_tag);
  end
endmodule

// File: rtl/l1tc_plru_store.sv
`timescale 1ns/1ps
// Per-set binary-tree replacement state and victim choice.
module l1tc_plru_store #(
  parameter  int SETS  = 16,
  parameter  int WAYS  = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  input  logic [WAYS-1:0]  valid_vec,
  output logic [WAY_W-1:0] victim,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic [WAY_W-1:0] upd_way,
  input  logic             clr_en,
  input  logic [SET_W-1:0] clr_set
);
  logic [NODES-1:0] tree_q [SETS];
  logic [NODES-1:0] tree_d [SETS];

  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t,
                                             input logic [WAY_W-1:0] way);
    logic [NODES-1:0] r;
    int n;
    r = t;
    n = 0;
    for (int l = WAY_W - 1; l >= 0; l--) begin
      r[n] = ~way[l];
      n    = 2 * n + 1 + int'(way[l]);
    end
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] walk(input logic [NODES-1:0] t);
    logic [WAY_W-1:0] v;
    logic b;
    int n;
    v = '0;
    n = 0;
    for (int l = WAY_W - 1; l >= 0; l--) begin
      b    = t[n];
      v[l] = b;
      n    = 2 * n + 1 + int'(b);
    end
    return v;
  endfunction

  logic             any_inv;
  logic [WAY_W-1:0] first_inv;

  always_comb begin
    any_inv   = 1'b0;
    first_inv = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_vec[w]) begin
        any_inv   = 1'b1;
        first_inv = WAY_W'(w);
      end
    end
    victim = any_inv ? first_inv : walk(tree_q[rd_set]);
  end

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      tree_d[s] = tree_q[s];
      if (upd_en && upd_set == SET_W'(s)) tree_d[s] = touch(tree_q[s], upd_way);
      if (clr_en && clr_set == SET_W'(s)) tree_d[s] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= tree_d[s];
    end
  end
endmodule

// File: rtl/l1_tag_ctrl.sv
`timescale 1ns/1ps
// Lockable L1 tag controller: lookup decision, snoop handling, result registers.
module l1_tag_ctrl
  import l1tc_pkg::*;
#(
  parameter  int SETS  = 16,
  parameter  int WAYS  = 8,
  parameter  int TAG_W = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             busy,
  input  logic             req_valid,
  input  logic [SET_W-1:0] req_set,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_inhibit,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [WAY_W-1:0] rsp_way,
  output logic             bus_req,
  output logic             bus_single,
  output logic             bus_ci,
  output logic [SET_W-1:0] bus_set,
  output logic [TAG_W-1:0] bus_tag,
  input  logic             snp_valid,
  input  logic [SET_W-1:0] snp_set,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic             snp_inval,
  output logic             snp_hit
);
  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  logic [CFG_W-1:0] cfg_q;
  logic             busy_i;
  logic [SET_W-1:0] clr_set;

  l1tc_cfg_seq #(.SETS(SETS)) u_cfg (
    .clk(clk), .rst_n(rst_sn), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .busy(busy_i), .clr_set(clr_set)
  );

  logic [WAYS-1:0]  hit_vec, valid_vec, snp_vec;
  logic [WAY_W-1:0] victim, hit_way, upd_way;
  logic             accept, cacheable, hit_any, snp_go;
  acc_kind_e        kind;

  l1tc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_sn),
    .core_set(req_set), .core_tag(req_tag),
    .core_hit_vec(hit_vec), .core_valid_vec(valid_vec),
    .snp_set(snp_set), .snp_tag(snp_tag), .snp_hit_vec(snp_vec),
    .fill_en(kind == ACC_FILL), .fill_set(req_set), .fill_way(victim), .fill_tag(req_tag),
    .sinv_en(snp_go & snp_inval), .sinv_set(snp_set), .sinv_vec(snp_vec),
    .clr_en(busy_i), .clr_set(clr_set)
  );

  l1tc_plru_store #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk(clk), .rst_n(rst_sn),
    .rd_set(req_set), .valid_vec(valid_vec), .victim(victim),
    .upd_en(kind == ACC_HIT || kind == ACC_FILL), .upd_set(req_set), .upd_way(upd_way),
    .clr_en(busy_i), .clr_set(clr_set)
  );

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  // lookup decision
  always_comb begin
    accept    = req_valid & ~busy_i;
    cacheable = cfg_q[CFG_EN] & ~req_inhibit;
    hit_any   = cacheable & (|hit_vec);
    if (!accept)                           kind = ACC_NONE;
    else if (hit_any)                      kind = ACC_HIT;
    else if (cacheable && !cfg_q[CFG_LOCK]) kind = ACC_FILL;
    else                                   kind = ACC_SINGLE;
    upd_way = (kind == ACC_HIT) ? hit_way : victim;
    snp_go  = snp_valid & cfg_q[CFG_EN] & ~busy_i;
  end

  // result registers: next state
  logic             rsp_valid_q, rsp_valid_d;
  logic             rsp_hit_q, rsp_hit_d;
  logic [WAY_W-1:0] rsp_way_q, rsp_way_d;
  logic             bus_req_q, bus_req_d;
  logic             bus_single_q, bus_single_d;
  logic             bus_ci_q, bus_ci_d;
  logic [SET_W-1:0] bus_set_q;
  logic [TAG_W-1:0] bus_tag_q;
  logic             snp_hit_q, snp_hit_d;

  always_comb begin
    rsp_valid_d  = accept;
    rsp_hit_d    = (kind == ACC_HIT);
    rsp_way_d    = (kind == ACC_HIT || kind == ACC_FILL) ? upd_way : '0;
    bus_req_d    = (kind == ACC_FILL) || (kind == ACC_SINGLE);
    bus_single_d = (kind == ACC_SINGLE);
    bus_ci_d     = accept & req_inhibit;
    snp_hit_d    = snp_go & (|snp_vec);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rsp_valid_q  <= 1'b0;
      rsp_hit_q    <= 1'b0;
      rsp_way_q    <= '0;
      bus_req_q    <= 1'b0;
      bus_single_q <= 1'b0;
      bus_ci_q     <= 1'b0;
      snp_hit_q    <= 1'b0;
    end else begin
      rsp_valid_q  <= rsp_valid_d;
      rsp_hit_q    <= rsp_hit_d;
      rsp_way_q    <= rsp_way_d;
      bus_req_q    <= bus_req_d;
      bus_single_q <= bus_single_d;
      bus_ci_q     <= bus_ci_d;
      snp_hit_q    <= snp_hit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      bus_set_q <= '0;
      bus_tag_q <= '0;
    end else if (accept) begin
      bus_set_q <= req_set;
      bus_tag_q <= req_tag;
    end
  end

  assign cfg_rdata  = cfg_q;
  assign busy       = busy_i;
  assign req_ready  = ~busy_i;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_hit    = rsp_hit_q;
  assign rsp_way    = rsp_way_q;
  assign bus_req    = bus_req_q;
  assign bus_single = bus_single_q;
  assign bus_ci     = bus_ci_q;
  assign bus_set    = bus_set_q;
  assign bus_tag    = bus_tag_q;
  assign snp_hit    = snp_hit_q;
endmodule

// File: rtl/l1tc_checker.sv
`timescale 1ns/1ps
module l1tc_checker
  import l1tc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             busy,
  input logic             req_valid,
  input logic             req_inhibit,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             bus_req,
  input logic             bus_single,
  input logic             bus_ci,
  input logic             snp_valid,
  input logic             snp_hit
);
  // R2: a hit never also requests the bus
  p_hit_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_valid && !bus_req));

  // R4: disabled lookups go out single-beat and never hit
  p_off_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_rdata[CFG_EN]) |=> (bus_req && bus_single && !rsp_hit));

  // R4: disabled snoops report no hit
  p_off_snoop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !cfg_rdata[CFG_EN]) |=> !snp_hit);

  // R5: bus_ci tracks the inhibit attribute of the accepted access
  p_ci_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid && bus_ci == $past(req_inhibit)));

  // R6: a locked miss never asks for a burst fill
  p_lock_noburst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cfg_rdata[CFG_LOCK]) |=> !(bus_req && !bus_single));

  // R8: the flash bit reads high for one cycle only
  p_finv_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[CFG_FINV] |=> !cfg_rdata[CFG_FINV]);

  // R8: no lookup is accepted during the walk
  p_busy_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rsp_valid);

  // R8: snoops during the walk miss
  p_busy_snoop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !snp_hit);
endmodule

bind l1_tag_ctrl l1tc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .busy(busy),
  .req_valid(req_valid), .req_inhibit(req_inhibit), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .bus_req(bus_req),
  .bus_single(bus_single), .bus_ci(bus_ci), .snp_valid(snp_valid), .snp_hit(snp_hit)
);

// File: tb/sim_l1_tag_ctrl.sv
`timescale 1ns/1ps
module sim_l1_tag_ctrl;
  localparam int SETS = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [2:0] cfg_wdata;
  logic [2:0] cfg_rdata;
  logic       busy;
  logic       req_valid;
  logic [3:0] req_set;
  logic [7:0] req_tag;
  logic       req_inhibit;
  logic       req_ready;
  logic       rsp_valid, rsp_hit;
  logic [2:0] rsp_way;
  logic       bus_req, bus_single, bus_ci;
  logic [3:0] bus_set;
  logic [7:0] bus_tag;
  logic       snp_valid;
  logic [3:0] snp_set;
  logic [7:0] snp_tag;
  logic       snp_inval;
  logic       snp_hit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  l1_tag_ctrl #(.SETS(SETS), .WAYS(8), .TAG_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .busy(busy),
    .req_valid(req_valid), .req_set(req_set), .req_tag(req_tag),
    .req_inhibit(req_inhibit), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .bus_req(bus_req), .bus_single(bus_single), .bus_ci(bus_ci),
    .bus_set(bus_set), .bus_tag(bus_tag),
    .snp_valid(snp_valid), .snp_set(snp_set), .snp_tag(snp_tag),
    .snp_inval(snp_inval), .snp_hit(snp_hit)
  );

  typedef struct packed {
    logic [7:0] tag;
    logic       inh;
    logic       hit;
    logic [2:0] way;
    logic       breq;
    logic       single;
  } vec_t;

  // all on set 3, cache enabled and unlocked
  localparam vec_t TBL [18] = '{
    '{8'hA1, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0},
    '{8'hA1, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0},
    '{8'hA2, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0},
    '{8'hA3, 1'b0, 1'b0, 3'd2, 1'b1, 1'b0},
    '{8'hA4, 1'b0, 1'b0, 3'd3, 1'b1, 1'b0},
    '{8'hA5, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0},
    '{8'hA6, 1'b0, 1'b0, 3'd5, 1'b1, 1'b0},
    '{8'hA7, 1'b0, 1'b0, 3'd6, 1'b1, 1'b0},
    '{8'hA8, 1'b0, 1'b0, 3'd7, 1'b1, 1'b0},
    '{8'hA9, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0},
    '{8'hA1, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0},
    '{8'hA2, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0},
    '{8'hAA, 1'b0, 1'b0, 3'd6, 1'b1, 1'b0},
    '{8'hA9, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0},
    '{8'hA5, 1'b0, 1'b0, 3'd5, 1'b1, 1'b0},
    '{8'hA6, 1'b0, 1'b0, 3'd2, 1'b1, 1'b0},
    '{8'hA8, 1'b1, 1'b0, 3'd0, 1'b1, 1'b1},
    '{8'hA8, 1'b0, 1'b1, 3'd7, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic [3:0] s, input logic [7:0] t, input logic inh);
    @(negedge clk);
    req_valid = 1'b1; req_set = s; req_tag = t; req_inhibit = inh;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic snoop(input logic [3:0] s, input logic [7:0] t, input logic inv);
    @(negedge clk);
    snp_valid = 1'b1; snp_set = s; snp_tag = t; snp_inval = inv;
    @(posedge clk); #1;
    snp_valid = 1'b0;
  endtask

  // expect: kind 0 = hit, 1 = burst fill, 2 = single beat
  task automatic expect_acc(input string rq, input int kind, input logic [2:0] way);
    check(rsp_valid === 1'b1, rq, rsp_valid, 1);
    check(rsp_hit === (kind == 0), rq, rsp_hit, kind == 0);
    check(bus_req === (kind != 0), rq, bus_req, kind != 0);
    if (kind != 0) check(bus_single === (kind == 2), rq, bus_single, kind == 2);
    if (kind != 2) check(rsp_way === way, rq, rsp_way, way);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_wdata = '0;
    req_valid = 1'b0; req_set = '0; req_tag = '0; req_inhibit = 1'b0;
    snp_valid = 1'b0; snp_set = '0; snp_tag = '0; snp_inval = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1 reset state
    check(cfg_rdata === 3'b000, "R1 cfg", cfg_rdata, 0);
    check(busy === 1'b0, "R1 busy", busy, 0);
    check(req_ready === 1'b1, "R1 ready", req_ready, 1);
    check(rsp_valid === 1'b0 && bus_req === 1'b0 && snp_hit === 1'b0, "R1 outputs",
          {rsp_valid, bus_req, snp_hit}, 0);

    // R4 disabled: single beat, no allocation (table step 0 then misses)
    access(4'd3, 8'hA1, 1'b0);
    expect_acc("R4 disabled access", 2, 3'd0);
    check(bus_ci === 1'b0, "R5 ci disabled", bus_ci, 0);
    access(4'd3, 8'hA1, 1'b1);
    check(bus_ci === 1'b1 && bus_single === 1'b1, "R5 ci disabled inh", bus_ci, 1);

    cfg_write(3'b001);

    // R2 R3 R5 vector table
    for (int i = 0; i < 18; i++) begin
      access(4'd3, TBL[i].tag, TBL[i].inh);
      expect_acc($sformatf("R3 vec %0d", i), TBL[i].hit ? 0 : (TBL[i].single ? 2 : 1), TBL[i].way);
      check(bus_ci === TBL[i].inh, "R5 ci", bus_ci, TBL[i].inh);
      if (TBL[i].breq)
        check(bus_tag === TBL[i].tag && bus_set === 4'd3, "R2 bus addr", bus_tag, TBL[i].tag);
    end
    // set 3 now: w0 A9 w1 A2 w2 A6 w3 A4 w4 A1 w5 A5 w6 AA w7 A8

    access(4'd5, 8'hA1, 1'b0);
    expect_acc("R2 other set", 1, 3'd0);

    // R6 lock
    cfg_write(3'b011);
    access(4'd3, 8'hA4, 1'b0);
    expect_acc("R6 locked hit", 0, 3'd3);
    access(4'd3, 8'hA3, 1'b0);
    expect_acc("R6 locked miss", 2, 3'd0);
    access(4'd3, 8'hA3, 1'b0);
    expect_acc("R6 no alloc", 2, 3'd0);

    // R7 snoop under lock
    snoop(4'd3, 8'hA4, 1'b1);
    check(snp_hit === 1'b1, "R7 snoop hit", snp_hit, 1);
    access(4'd3, 8'hA4, 1'b0);
    expect_acc("R7 stays invalid", 2, 3'd0);
    snoop(4'd3, 8'hA4, 1'b0);
    check(snp_hit === 1'b0, "R7 snoop after inval", snp_hit, 0);
    snoop(4'd3, 8'hA2, 1'b0);
    check(snp_hit === 1'b1, "R7 snoop probe", snp_hit, 1);

    // unlock: refill into the invalid way, then tree victim
    cfg_write(3'b001);
    access(4'd3, 8'hA4, 1'b0);
    expect_acc("R7 refill after unlock", 1, 3'd3);
    access(4'd3, 8'hA3, 1'b0);
    expect_acc("R3 tree victim", 1, 3'd4);

    // R11 write in same cycle as lookup
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 3'b000;
    req_valid = 1'b1; req_set = 4'd3; req_tag = 8'hA2; req_inhibit = 1'b0;
    @(posedge clk); #1;
    cfg_we = 1'b0; req_valid = 1'b0;
    expect_acc("R11 old enable used", 0, 3'd1);
    access(4'd3, 8'hA2, 1'b0);
    expect_acc("R11 new value applies", 2, 3'd0);

    // R4 disabled snoop has no effect
    snoop(4'd3, 8'hA2, 1'b1);
    check(snp_hit === 1'b0, "R4 disabled snoop", snp_hit, 0);

    // R10 flash with enable low
    cfg_write(3'b100);
    check(cfg_rdata === 3'b100, "R10 flash pulse", cfg_rdata, 3'b100);
    check(busy === 1'b0, "R10 no walk", busy, 0);
    @(posedge clk); #1;
    check(cfg_rdata === 3'b000, "R10 flash clears", cfg_rdata, 0);
    cfg_write(3'b001);
    access(4'd3, 8'hA2, 1'b0);
    expect_acc("R10 R4 line kept", 0, 3'd1);

    // R8 R9 flash invalidate walk
    cfg_write(3'b101);
    check(cfg_rdata === 3'b101, "R8 flash reads 1", cfg_rdata, 3'b101);
    check(busy === 1'b1 && req_ready === 1'b0, "R8 busy start", {busy, req_ready}, 2'b10);
    begin
      int nb = 1;
      int it = 0;
      while (busy === 1'b1 && it < 100) begin
        @(negedge clk);
        snp_valid = (it == 0); snp_set = 4'd3; snp_tag = 8'hA2; snp_inval = 1'b0;
        req_valid = (it == 0); req_set = 4'd3; req_tag = 8'hA2; req_inhibit = 1'b0;
        cfg_we = (it == 2); cfg_wdata = 3'b101;
        @(posedge clk); #1;
        if (it == 0) begin
          check(snp_hit === 1'b0, "R8 snoop forced miss", snp_hit, 0);
          check(rsp_valid === 1'b0, "R8 stall", rsp_valid, 0);
          check(cfg_rdata === 3'b001, "R8 flash self clears", cfg_rdata, 3'b001);
        end
        if (it == 2) check(cfg_rdata === 3'b001, "R9 flash ignored", cfg_rdata, 3'b001);
        if (busy === 1'b1) nb++;
        it++;
      end
      snp_valid = 1'b0; req_valid = 1'b0; cfg_we = 1'b0;
      check(nb == SETS, "R8 R9 busy length", nb, SETS);
    end
    check(req_ready === 1'b1, "R8 ready back", req_ready, 1);
    access(4'd3, 8'hA2, 1'b0);
    expect_acc("R8 cleared set3", 1, 3'd0);
    access(4'd5, 8'hA1, 1'b0);
    expect_acc("R8 cleared set5", 1, 3'd0);
    snoop(4'd3, 8'hA9, 1'b0);
    check(snp_hit === 1'b0, "R8 old line gone", snp_hit, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule